// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between the write side of a parallel flash bus and the program/erase controller. Every accepted bus write (an address and a data byte) is fed to it as a one-cycle strobe. It follows the multi-write unlock handshakes of the command set. It turns complete sequences into one-cycle request pulses: reset, program (with the latched target address and data), chip erase, block erase (with a mask of selected blocks), suspend and resume. A short-cut programming mode lets a host program with two writes per byte instead of four.

The controller reports its own state back on a two-bit input and an error flag. The decoder uses them to filter which writes are honoured, and to choose what a bus read should return. The choices are array data, identification data, or the controller's status. While the decoder is in identification mode, it also produces the identification byte for the current read address.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The unlock prefix is data AA written at command address 555h, then data 55 at 2AAh. Only address bits 10:0 are compared, so any upper bits are accepted.
- R2: After the prefix, a write at 555h selects the command. Data 90 enters identification mode. Data A0 arms a program, and the next write at any address pulses `reqProgram` with that write's address and data on `progAddr`/`progData`. Data 20 enters bypass mode.
- R3: Prefix, 80 at 555h, a second prefix, then 10 at 555h pulses `reqChipErase`. Any other final address gives no chip erase.
- R4: Data F0 pulses `reqReset` and leaves identification mode. It may be written once at any address or after the prefix.
- R5: A write that does not continue a valid sequence issues no request and returns the read mode to array (0).
- R6: In bypass mode, A0 followed by one write programs, and 90 followed by 00 leaves the mode. Every other write is ignored, including a full unlock prefix, and the read mode stays array.
- R7: A block erase is prefix, 80, prefix, then 30 at an address whose bits 18:16 name the block. This opens a selection window of WINDOW_CYC cycles. Each further 30 write adds its block and restarts the window. `reqBlockErase` pulses once, WINDOW_CYC cycles after the last add, with `eraseMask` bit b set for each selected block b.
- R8: A0 B0 write while the controller state is 2 (block erase running) pulses `reqSuspend`. A 30 write while the state is 3 (suspended) pulses `reqResume`. A B0 write inside the selection window closes it at once: `reqBlockErase` and `reqSuspend` pulse in the same cycle.
- R9: While the controller state is 1 (program or chip erase running), every write is ignored.
- R10: While the controller state is 2, only B0 (suspend) and F0 (reset) are honoured. A program sequence gives no request.
- R11: In identification mode, `idData` follows read address bits 1:0. 00 gives 20h, 01 gives E2h, and 11 gives 00h. 10 gives 01h if `protMask` bit b is set for the block b in bits 18:16, and 00h otherwise.
- R12: While `ctrlError` is high, only F0 is honoured and pulses `reqReset`. Bypass mode survives that reset.
- R13: A program whose target lies in a block with its `protMask` bit set is dropped: no `reqProgram`, and the decoder returns to its idle step.
- R14: `readMode` is 2 (status) while the controller state is 1 or 2, while `ctrlError` is high, or while the selection window is open. Otherwise it is 1 in identification mode and 0 for array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | One-cycle strobe of an accepted bus write |
| wrAddr | input | ADDR_W | Address of the bus write |
| wrData | input | 8 | Data byte of the bus write |
| ctrlState | input | 2 | Controller state: 0 idle, 1 program/chip erase, 2 block erase, 3 suspended |
| ctrlError | input | 1 | Controller reports a failed operation |
| protMask | input | 2**BLK_W | Per-block protection flags |
| rdAddr | input | ADDR_W | Current bus read address |
| reqReset | output | 1 | Reset request pulse |
| reqProgram | output | 1 | Program request pulse |
| progAddr | output | ADDR_W | Program target address |
| progData | output | 8 | Program data |
| reqChipErase | output | 1 | Chip erase request pulse |
| reqBlockErase | output | 1 | Block erase request pulse |
| eraseMask | output | 2**BLK_W | Blocks selected for erase |
| reqSuspend | output | 1 | Erase suspend request pulse |
| reqResume | output | 1 | Erase resume request pulse |
| bypassMode | output | 1 | Short-cut programming mode active |
| readMode | output | 2 | 0 array, 1 identification, 2 status |
| idData | output | 8 | Identification byte for `rdAddr` |

## Verification
The bench uses the default 19-bit address and 3-bit block index, so eight blocks make the protection and identification sweeps complete. WINDOW_CYC is set to 4, so the window expiry can be checked on its exact cycle after a restart. It sweeps all 256 values of the command byte after the prefix. It also sweeps every block against fixed protection patterns, for both programming and identification reads. It then drives each controller state to exercise the filtering, suspend and error paths.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    CS_IDLE     = 2'd0,
    CS_BUSY     = 2'd1,
    CS_BLKERASE = 2'd2,
    CS_SUSPEND  = 2'd3
  } ctrl_state_e;

  typedef enum logic [1:0] {
    RM_ARRAY   = 2'd0,
    RM_AUTOSEL = 2'd1,
    RM_STATUS  = 2'd2
  } read_mode_e;

  typedef struct packed {
    logic latchProg;
    logic maskLoad;
    logic maskAdd;
    logic winFlush;
    logic winCancel;
  } dp_strobe_t;

  localparam int CMD_AW = 11;
  localparam logic [CMD_AW-1:0] UNLOCK_A1 = 11'h555;
  localparam logic [CMD_AW-1:0] UNLOCK_A2 = 11'h2AA;

  localparam logic [7:0] D_KEY1    = 8'hAA;
  localparam logic [7:0] D_KEY2    = 8'h55;
  localparam logic [7:0] D_IDENT   = 8'h90;
  localparam logic [7:0] D_PROG    = 8'hA0;
  localparam logic [7:0] D_BYPASS  = 8'h20;
  localparam logic [7:0] D_ERASE   = 8'h80;
  localparam logic [7:0] D_CHIP    = 8'h10;
  localparam logic [7:0] D_BLOCK   = 8'h30;
  localparam logic [7:0] D_SUSPEND = 8'hB0;
  localparam logic [7:0] D_RESET   = 8'hF0;
  localparam logic [7:0] D_BPEXIT  = 8'h00;

  localparam logic [7:0] MFR_CODE = 8'h20;
  localparam logic [7:0] DEV_CODE = 8'hE2;

endpackage

// File: rtl/fcd_dpath.sv
module fcd_dpath
  import fcd_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int BLK_W      = 3,
  parameter int WINDOW_CYC = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dp_strobe_t            strobe,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [7:0]            wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic [(1<<BLK_W)-1:0] protMask,
  output logic [ADDR_W-1:0]     progAddr,
  output logic [7:0]            progData,
  output logic [(1<<BLK_W)-1:0] eraseMask,
  output logic                  winOpen,
  output logic                  winExpire,
  output logic                  wrProtected,
  output logic [7:0]            idData
);

  localparam int NUM_BLK = 1 << BLK_W;
  localparam int CNT_W   = $clog2(WINDOW_CYC + 1);

  logic [BLK_W-1:0]   wrBlk;
  logic [BLK_W-1:0]   rdBlk;
  logic [NUM_BLK-1:0] wrBlkHot;
  logic [CNT_W-1:0]   winCnt;
  logic               unusedRdBits;

  assign wrBlk = wrAddr[ADDR_W-1 -: BLK_W];
  assign rdBlk = rdAddr[ADDR_W-1 -: BLK_W];
  assign unusedRdBits = ^rdAddr[ADDR_W-BLK_W-1:2];

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blkDec
    assign wrBlkHot[g] = (wrBlk == BLK_W'(g));
  end

  assign wrProtected = |(wrBlkHot & protMask);

  // program target latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      progAddr <= '0;
      progData <= '0;
    end else if (strobe.latchProg) begin
      progAddr <= wrAddr;
      progData <= wrData;
    end
  end

  // block selection mask
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eraseMask <= '0;
    end else if (strobe.maskLoad) begin
      eraseMask <= wrBlkHot;
    end else if (strobe.maskAdd) begin
      eraseMask <= eraseMask | wrBlkHot;
    end
  end

  // selection window timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winOpen   <= 1'b0;
      winCnt    <= '0;
      winExpire <= 1'b0;
    end else begin
      winExpire <= 1'b0;
      if (strobe.maskLoad || strobe.maskAdd) begin
        winOpen <= 1'b1;
        winCnt  <= CNT_W'(WINDOW_CYC - 1);
      end else if (winOpen) begin
        if (strobe.winCancel) begin
          winOpen <= 1'b0;
        end else if (strobe.winFlush || winCnt == '0) begin
          winOpen   <= 1'b0;
          winExpire <= 1'b1;
        end else begin
          winCnt <= winCnt - 1'b1;
        end
      end
    end
  end

  // identification data
  always_comb begin
    case (rdAddr[1:0])
      2'b00:   idData = MFR_CODE;
      2'b01:   idData = DEV_CODE;
      2'b10:   idData = {7'd0, protMask[rdBlk]};
      default: idData = 8'h00;
    endcase
  end

  // R7
  expire_after_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    winExpire |-> $past(winOpen));

  // R7
  mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    winExpire |-> (eraseMask != '0));

endmodule

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [CMD_AW-1:0] cmdAddr,
  input  logic [7:0]        wrData,
  input  ctrl_state_e       ctrlState,
  input  logic              ctrlError,
  input  logic              winOpen,
  input  logic              wrProtected,
  output dp_strobe_t        strobe,
  output logic              reqReset,
  output logic              reqProgram,
  output logic              reqChipErase,
  output logic              reqSuspend,
  output logic              reqResume,
  output logic              bypassMode,
  output logic              autoselMode
);

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PROG, SQ_E1, SQ_E2, SQ_E3, SQ_BPROG, SQ_BEXIT
  } seq_e;

  seq_e seqQ, seqNext;
  logic bypassQ, bypassNext;
  logic autoselQ, autoselNext;
  logic rstN, progN, chipN, susN, resN;
  logic isA1, isA2, eraseOk;

  assign isA1    = (cmdAddr == UNLOCK_A1);
  assign isA2    = (cmdAddr == UNLOCK_A2);
  assign eraseOk = (ctrlState == CS_IDLE);

  always_comb begin
    seqNext     = seqQ;
    bypassNext  = bypassQ;
    autoselNext = autoselQ;
    strobe      = '0;
    rstN = 1'b0; progN = 1'b0; chipN = 1'b0; susN = 1'b0; resN = 1'b0;
    if (wrEn) begin
      if (ctrlError) begin
        if (wrData == D_RESET) begin
          rstN        = 1'b1;
          autoselNext = 1'b0;
          seqNext     = SQ_IDLE;
        end
      end else begin
        case (ctrlState)
          CS_BUSY: ;
          CS_BLKERASE: begin
            if (wrData == D_SUSPEND)    susN = 1'b1;
            else if (wrData == D_RESET) rstN = 1'b1;
          end
          default: begin
            if (winOpen) begin
              if (wrData == D_BLOCK) begin
                strobe.maskAdd = 1'b1;
              end else if (wrData == D_SUSPEND) begin
                strobe.winFlush = 1'b1;
                susN            = 1'b1;
              end else if (wrData == D_RESET) begin
                strobe.winCancel = 1'b1;
                rstN             = 1'b1;
              end
            end else if (ctrlState == CS_SUSPEND && seqQ == SQ_IDLE &&
                         !bypassQ && wrData == D_BLOCK) begin
              resN = 1'b1;
            end else if (bypassQ) begin
              seqNext = SQ_IDLE;
              case (seqQ)
                SQ_IDLE: begin
                  if (wrData == D_PROG)       seqNext = SQ_BPROG;
                  else if (wrData == D_IDENT) seqNext = SQ_BEXIT;
                end
                SQ_BPROG: begin
                  if (!wrProtected) begin
                    strobe.latchProg = 1'b1;
                    progN            = 1'b1;
                  end
                end
                SQ_BEXIT: begin
                  if (wrData == D_BPEXIT) bypassNext = 1'b0;
                end
                default: ;
              endcase
            end else begin
              seqNext = SQ_IDLE;
              case (seqQ)
                SQ_IDLE: begin
                  if (wrData == D_RESET) begin
                    rstN        = 1'b1;
                    autoselNext = 1'b0;
                  end else if (wrData == D_KEY1 && isA1) begin
                    seqNext = SQ_U1;
                  end else begin
                    autoselNext = 1'b0;
                  end
                end
                SQ_U1: begin
                  if (wrData == D_KEY2 && isA2) seqNext = SQ_U2;
                  else autoselNext = 1'b0;
                end
                SQ_U2: begin
                  if (wrData == D_RESET) begin
                    rstN        = 1'b1;
                    autoselNext = 1'b0;
                  end else if (isA1 && wrData == D_IDENT) begin
                    autoselNext = 1'b1;
                  end else if (isA1 && wrData == D_PROG) begin
                    seqNext = SQ_PROG;
                  end else if (isA1 && wrData == D_BYPASS) begin
                    bypassNext  = 1'b1;
                    autoselNext = 1'b0;
                  end else if (isA1 && wrData == D_ERASE && eraseOk) begin
                    seqNext = SQ_E1;
                  end else begin
                    autoselNext = 1'b0;
                  end
                end
                SQ_PROG: begin
                  autoselNext = 1'b0;
                  if (!wrProtected) begin
                    strobe.latchProg = 1'b1;
                    progN            = 1'b1;
                  end
                end
                SQ_E1: begin
                  if (wrData == D_KEY1 && isA1) seqNext = SQ_E2;
                  else autoselNext = 1'b0;
                end
                SQ_E2: begin
                  if (wrData == D_KEY2 && isA2) seqNext = SQ_E3;
                  else autoselNext = 1'b0;
                end
                SQ_E3: begin
                  autoselNext = 1'b0;
                  if (wrData == D_CHIP && isA1) chipN = 1'b1;
                  else if (wrData == D_BLOCK)   strobe.maskLoad = 1'b1;
                end
                default: autoselNext = 1'b0;
              endcase
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seqQ         <= SQ_IDLE;
      bypassQ      <= 1'b0;
      autoselQ     <= 1'b0;
      reqReset     <= 1'b0;
      reqProgram   <= 1'b0;
      reqChipErase <= 1'b0;
      reqSuspend   <= 1'b0;
      reqResume    <= 1'b0;
    end else begin
      seqQ         <= seqNext;
      bypassQ      <= bypassNext;
      autoselQ     <= autoselNext;
      reqReset     <= rstN;
      reqProgram   <= progN;
      reqChipErase <= chipN;
      reqSuspend   <= susN;
      reqResume    <= resN;
    end
  end

  assign bypassMode  = bypassQ;
  assign autoselMode = autoselQ;

  // R2
  single_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reqReset, reqProgram, reqChipErase, reqSuspend, reqResume}));

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlState == CS_BUSY && !ctrlError) |=>
      !(reqReset || reqProgram || reqChipErase || reqSuspend || reqResume));

  // R10
  blk_erase_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlState == CS_BLKERASE) |=> !(reqProgram || reqChipErase || reqResume));

  // R6
  bypass_no_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqChipErase |-> !$past(bypassQ));

  // R12
  error_reset_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlError |=> !(reqProgram || reqChipErase || reqSuspend || reqResume));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int BLK_W      = 3,
  parameter int WINDOW_CYC = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [7:0]            wrData,
  input  logic [1:0]            ctrlState,
  input  logic                  ctrlError,
  input  logic [(1<<BLK_W)-1:0] protMask,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic                  reqReset,
  output logic                  reqProgram,
  output logic [ADDR_W-1:0]     progAddr,
  output logic [7:0]            progData,
  output logic                  reqChipErase,
  output logic                  reqBlockErase,
  output logic [(1<<BLK_W)-1:0] eraseMask,
  output logic                  reqSuspend,
  output logic                  reqResume,
  output logic                  bypassMode,
  output logic [1:0]            readMode,
  output logic [7:0]            idData
);

  dp_strobe_t  strobe;
  ctrl_state_e ctrlStateE;
  logic        winOpen;
  logic        wrProtected;
  logic        autoselMode;

  assign ctrlStateE = ctrl_state_e'(ctrlState);

  fcd_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wrEn        (wrEn),
    .cmdAddr     (wrAddr[CMD_AW-1:0]),
    .wrData      (wrData),
    .ctrlState   (ctrlStateE),
    .ctrlError   (ctrlError),
    .winOpen     (winOpen),
    .wrProtected (wrProtected),
    .strobe      (strobe),
    .reqReset    (reqReset),
    .reqProgram  (reqProgram),
    .reqChipErase(reqChipErase),
    .reqSuspend  (reqSuspend),
    .reqResume   (reqResume),
    .bypassMode  (bypassMode),
    .autoselMode (autoselMode)
  );

  fcd_dpath #(
    .ADDR_W    (ADDR_W),
    .BLK_W     (BLK_W),
    .WINDOW_CYC(WINDOW_CYC)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .rdAddr     (rdAddr),
    .protMask   (protMask),
    .progAddr   (progAddr),
    .progData   (progData),
    .eraseMask  (eraseMask),
    .winOpen    (winOpen),
    .winExpire  (reqBlockErase),
    .wrProtected(wrProtected),
    .idData     (idData)
  );

  always_comb begin
    if (ctrlError || ctrlStateE == CS_BUSY || ctrlStateE == CS_BLKERASE || winOpen)
      readMode = RM_STATUS;
    else if (autoselMode)
      readMode = RM_AUTOSEL;
    else
      readMode = RM_ARRAY;
  end

endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;

  localparam int AW = 19;
  localparam int BW = 3;
  localparam int NB = 1 << BW;
  localparam int WC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0]    wrData = '0;
  logic [1:0]    ctrlState = 2'd0;
  logic          ctrlError = 1'b0;
  logic [NB-1:0] protMask = '0;
  logic [AW-1:0] rdAddr = '0;
  logic          reqReset, reqProgram, reqChipErase, reqBlockErase;
  logic          reqSuspend, reqResume, bypassMode;
  logic [AW-1:0] progAddr;
  logic [7:0]    progData, idData;
  logic [NB-1:0] eraseMask;
  logic [1:0]    readMode;

  int nChecks = 0;
  int nErr = 0;
  int cRst = 0, cProg = 0, cChip = 0, cBlk = 0, cSus = 0, cRes = 0, cBoth = 0;
  logic [AW-1:0] lastPA = '0;
  logic [7:0]    lastPD = '0;
  logic [NB-1:0] lastMask = '0;

  flash_cmd_decoder #(.ADDR_W(AW), .BLK_W(BW), .WINDOW_CYC(WC)) dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ctrlState(ctrlState), .ctrlError(ctrlError), .protMask(protMask),
    .rdAddr(rdAddr), .reqReset(reqReset), .reqProgram(reqProgram),
    .progAddr(progAddr), .progData(progData), .reqChipErase(reqChipErase),
    .reqBlockErase(reqBlockErase), .eraseMask(eraseMask),
    .reqSuspend(reqSuspend), .reqResume(reqResume), .bypassMode(bypassMode),
    .readMode(readMode), .idData(idData)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (reqReset) cRst++;
    if (reqProgram) begin cProg++; lastPA = progAddr; lastPD = progData; end
    if (reqChipErase) cChip++;
    if (reqBlockErase) begin cBlk++; lastMask = eraseMask; end
    if (reqSuspend) cSus++;
    if (reqResume) cRes++;
    if (reqBlockErase && reqSuspend) cBoth++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    #1;
  endtask

  task automatic prefix();
    wr(19'h00555, 8'hAA);
    wr(19'h002AA, 8'h55);
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    int r0, p0, c0, b0, s0, q0;
    doReset();
    // reset state
    chk("R14 reset readMode", 32'(readMode), 32'd0);
    chk("R6 reset bypass", 32'(bypassMode), 32'd0);
    chk("R2 reset no program", 32'(cProg), 32'd0);

    // R2 R4 R5 sweep of the command byte after the prefix
    for (int d = 0; d < 256; d++) begin
      int eRst, eProg, eMode, eByp;
      doReset();
      r0 = cRst; p0 = cProg;
      prefix();
      wr(19'h00555, 8'(d));
      eMode = (d == 8'h90) ? 1 : 0;
      eByp  = (d == 8'h20) ? 1 : 0;
      chk($sformatf("R2 mode after %02h", d), 32'(readMode), 32'(eMode));
      chk($sformatf("R5 bypass after %02h", d), 32'(bypassMode), 32'(eByp));
      wr(19'h12345, 8'h5A);
      eRst  = (d == 8'hF0) ? 1 : 0;
      eProg = (d == 8'hA0) ? 1 : 0;
      chk($sformatf("R4 reset count %02h", d), 32'(cRst - r0), 32'(eRst));
      chk($sformatf("R2 program count %02h", d), 32'(cProg - p0), 32'(eProg));
    end
    chk("R2 program addr", 32'(lastPA), 32'h12345);
    chk("R2 program data", 32'(lastPD), 32'h5A);

    // R1 upper address bits ignored, low bits compared
    doReset();
    wr(19'h7F555, 8'hAA); wr(19'h402AA, 8'h55); wr(19'h31555, 8'h90);
    chk("R1 upper bits ignored", 32'(readMode), 32'd1);
    // R4 single F0 leaves identification mode
    r0 = cRst;
    wr(19'h0ABCD, 8'hF0);
    chk("R4 single reset pulse", 32'(cRst - r0), 32'd1);
    chk("R4 leaves ident", 32'(readMode), 32'd0);
    // R1 wrong low address breaks
    wr(19'h00554, 8'hAA); wr(19'h002AA, 8'h55); wr(19'h00555, 8'h90);
    chk("R1 wrong address", 32'(readMode), 32'd0);
    // R5 stray write leaves identification mode
    prefix(); wr(19'h00555, 8'h90);
    wr(19'h00100, 8'h77);
    chk("R5 stray write", 32'(readMode), 32'd0);

    // R11 identification sweep
    for (int pm = 0; pm < 2; pm++) begin
      protMask = (pm == 0) ? 8'hA5 : 8'h3C;
      doReset();
      prefix(); wr(19'h00555, 8'h90);
      for (int b = 0; b < NB; b++) begin
        for (int s = 0; s < 4; s++) begin
          logic [7:0] e;
          rdAddr = {3'(b), 14'h1234, 2'(s)};
          #1;
          case (s)
            0: e = 8'h20;
            1: e = 8'hE2;
            2: e = {7'd0, protMask[b]};
            default: e = 8'h00;
          endcase
          chk($sformatf("R11 id blk%0d sel%0d", b, s), 32'(idData), 32'(e));
        end
      end
    end

    // R13 protected program sweep
    protMask = 8'b0100_1001;
    doReset();
    for (int b = 0; b < NB; b++) begin
      p0 = cProg;
      prefix(); wr(19'h00555, 8'hA0);
      wr({3'(b), 16'h0ABC}, 8'(b + 1));
      chk($sformatf("R13 program blk%0d", b), 32'(cProg - p0), 32'(protMask[b] ? 0 : 1));
      if (!protMask[b]) chk($sformatf("R13 data blk%0d", b), 32'(lastPD), 32'(b + 1));
    end
    protMask = '0;

    // R3 chip erase
    doReset();
    c0 = cChip;
    prefix(); wr(19'h00555, 8'h80); prefix(); wr(19'h00555, 8'h10);
    chk("R3 chip erase", 32'(cChip - c0), 32'd1);
    prefix(); wr(19'h00555, 8'h80); prefix(); wr(19'h00554, 8'h10);
    chk("R3 wrong final address", 32'(cChip - c0), 32'd1);

    // R7 block erase window with restart
    b0 = cBlk;
    prefix(); wr(19'h00555, 8'h80); prefix(); wr(19'h20000, 8'h30);
    chk("R14 status in window", 32'(readMode), 32'd2);
    @(negedge clk); #1;
    wr(19'h50000, 8'h30);
    repeat (WC - 1) @(negedge clk);
    #1;
    chk("R7 not yet expired", 32'(cBlk - b0), 32'd0);
    @(negedge clk); #1;
    chk("R7 expired on time", 32'(cBlk - b0), 32'd1);
    chk("R7 mask", 32'(lastMask), 32'h24);
    chk("R14 array after window", 32'(readMode), 32'd0);

    // R8 suspend inside window
    s0 = cSus;
    prefix(); wr(19'h00555, 8'h80); prefix(); wr(19'h70000, 8'h30);
    wr(19'h00000, 8'hB0);
    chk("R8 flush coincidence", 32'(cBoth), 32'd1);
    chk("R8 mask after flush", 32'(lastMask), 32'h80);

    // R9 busy ignores all
    ctrlState = 2'd1;
    r0 = cRst; p0 = cProg;
    prefix(); wr(19'h00555, 8'hA0); wr(19'h01000, 8'h11); wr(19'h0, 8'hF0);
    chk("R9 busy no program", 32'(cProg - p0), 32'd0);
    chk("R9 busy no reset", 32'(cRst - r0), 32'd0);
    chk("R14 busy status", 32'(readMode), 32'd2);

    // R10 block erase running
    ctrlState = 2'd2;
    doReset();
    p0 = cProg; s0 = cSus; r0 = cRst;
    prefix(); wr(19'h00555, 8'hA0); wr(19'h01000, 8'h11);
    chk("R10 no program", 32'(cProg - p0), 32'd0);
    wr(19'h0, 8'hB0);
    chk("R10 R8 suspend", 32'(cSus - s0), 32'd1);
    wr(19'h0, 8'hF0);
    chk("R10 reset", 32'(cRst - r0), 32'd1);

    // R8 resume while suspended
    ctrlState = 2'd3;
    doReset();
    q0 = cRes;
    wr(19'h10000, 8'h30);
    chk("R8 resume", 32'(cRes - q0), 32'd1);
    chk("R14 suspended array", 32'(readMode), 32'd0);
    ctrlState = 2'd0;

    // R6 bypass mode
    doReset();
    prefix(); wr(19'h00555, 8'h20);
    p0 = cProg;
    wr(19'h0, 8'hA0); wr(19'h33333, 8'hC3);
    chk("R6 two-write program", 32'(cProg - p0), 32'd1);
    chk("R6 program addr", 32'(lastPA), 32'h33333);
    prefix(); wr(19'h00555, 8'h90);
    chk("R6 prefix ignored", 32'(readMode), 32'd0);
    chk("R6 still bypass", 32'(bypassMode), 32'd1);
    wr(19'h0, 8'h01);
    chk("R6 exit needs 00", 32'(bypassMode), 32'd1);

    // R12 error handling in bypass
    ctrlError = 1'b1;
    p0 = cProg; r0 = cRst;
    wr(19'h0, 8'hA0); wr(19'h01000, 8'h22);
    chk("R12 program blocked", 32'(cProg - p0), 32'd0);
    chk("R12 R14 status on error", 32'(readMode), 32'd2);
    wr(19'h0, 8'hF0);
    chk("R12 reset", 32'(cRst - r0), 32'd1);
    ctrlError = 1'b0;
    chk("R12 bypass kept", 32'(bypassMode), 32'd1);
    wr(19'h0, 8'h90); wr(19'h0, 8'h00);
    chk("R6 exit", 32'(bypassMode), 32'd0);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule